// File: doc/BRIEF.md
# Lockable System Control Register Bank

This block is a small memory-mapped register bank that a processor reaches over a simple 32-bit word bus (address, write strobe, write data, read strobe, read data). It reports a fixed board identity, holds an LED word, two configuration words, a volatile flag word and a flag word that survives a board-level soft reset. Each flag word is read at one address and is changed through a write-one-to-set alias and a write-one-to-clear alias, so software never needs a read-modify-write sequence.

A reset control word is guarded by a 16-bit lock. Only while the lock holds the unlock key may the reset control word be written; a permitted write with the reset bit set raises a one-cycle board reset request. That same pulse acts as a soft clear for the volatile state inside the block, while the persistent flags are cleared only by the power-on reset input. Many offsets in the 4 KB window belong to functions that live elsewhere; they read as fixed constants or zero and ignore writes. Any other offset is undecoded: a read returns zero and flags an error for one cycle.

Top module: `sysctl_regbank`

## Requirements
- R1: After power-on reset (rst_n low) every writable register is 0, so the lock reads 0 (locked); byte offset 0x00 reads the BOARD_ID parameter, and bus_rdata, rd_err and board_rst_req are 0.
- R2: Byte offset 0x08 (LED word) and offsets 0x28 and 0x2C (configuration words A and B) are full 32-bit read/write registers.
- R3: The lock word at byte offset 0x20 is 16 bits, read zero-extended. A write whose full 32-bit data equals 0x0000A05F stores 0xA05F; any other write stores data bits 14:0 with bit 15 forced to 0.
- R4: The reset control word at byte offset 0x40 takes a write only while the lock word equals 0xA05F; at any other time the write is ignored.
- R5: A permitted write to offset 0x40 whose data bit 8 is 1 drives board_rst_req high for exactly one cycle, the cycle after the write's clock edge.
- R6: The volatile flag word reads at byte offset 0x30; a write to 0x30 ORs the data into it and a write to 0x34 clears every bit that is 1 in the data.
- R7: The persistent flag word reads at byte offset 0x38; a write to 0x38 sets bits and a write to 0x3C clears bits in the same way.
- R8: At the clock edge that ends a board_rst_req pulse, the LED, lock, configuration, volatile flag and reset control words return to 0, while the persistent flag word keeps its value.
- R9: Fixed reads: 0x44 reads 1, 0x50 reads 0x00001000, 0x84 reads 0x02000000, 0x88 reads 0xFF000000; offsets 0x04, 0x0C-0x1C, 0x24, 0x48, 0x4C, 0x54-0x74, 0x80, 0x8C-0x9C and 0xC0-0xD0 (word steps) read 0 without error; writes to all of these change nothing.
- R10: A read of any other offset, including 0x34, 0x3C and any address whose two low bits are not 00, returns 0 with rd_err high for one cycle; a write there changes no state.
- R11: Read data is registered: it appears in the cycle after bus_rd, holds while bus_rd is low, and a read in the same cycle as a write to the same register returns the value before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| bus_addr | input | 12 | Byte address inside the 4 KB window |
| bus_wr | input | 1 | Write strobe, acts on the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| rd_err | output | 1 | One-cycle flag for a read of an undecoded offset |
| board_rst_req | output | 1 | One-cycle board reset request |

## Verification
Every word offset of the window is read straight after reset and again after whole-window write passes with an all-ones word, with the exact unlock key and with a single-bit word, which separates the decoded registers, the constant offsets, the silent-zero offsets and the undecoded ones. Partial bit patterns on the set and clear aliases tell OR and AND-NOT behaviour apart from plain overwrite. Reset control writes are tried while locked, after a near-miss key and after the exact key, with and without bit 8, and the persistent flags are read back across the resulting soft clear. Misaligned addresses and a read colliding with a write to the same register cover the decode and timing edges.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int ADDR_W = 12;
  localparam int IDX_W  = ADDR_W - 2;
  localparam int REG_W  = 32;
  localparam int LOCK_W = 16;

  typedef logic [REG_W-1:0]  word_t;
  typedef logic [IDX_W-1:0]  widx_t;
  typedef logic [LOCK_W-1:0] key_t;

  // Word indices (byte offset / 4) of the decoded registers
  localparam widx_t WX_BOARD  = widx_t'(0);
  localparam widx_t WX_LAMP   = widx_t'(2);
  localparam widx_t WX_KEY    = widx_t'(8);
  localparam widx_t WX_CFG_A  = widx_t'(10);
  localparam widx_t WX_CFG_B  = widx_t'(11);
  localparam widx_t WX_VF_SET = widx_t'(12);
  localparam widx_t WX_VF_CLR = widx_t'(13);
  localparam widx_t WX_NV_SET = widx_t'(14);
  localparam widx_t WX_NV_CLR = widx_t'(15);
  localparam widx_t WX_RSTCTL = widx_t'(16);

  // Value stored into the lock word for a given write
  function automatic key_t lock_next(word_t wd, key_t key);
    if (wd == word_t'(key)) return key;
    return {1'b0, wd[LOCK_W-2:0]};
  endfunction

  // Next value of a set/clear flag word
  function automatic word_t flag_next(word_t cur, logic set_en, logic clr_en, word_t wd);
    if (clr_en) return cur & ~wd;
    if (set_en) return cur | wd;
    return cur;
  endfunction

  // Offsets that belong to functions outside this block: read 0, no error
  function automatic logic is_quiet(widx_t ix);
    int n;
    n = int'(ix);
    case (n)
      1, 3, 4, 5, 6, 7, 9, 18, 19, 21, 22, 23, 24, 25, 26, 27, 28, 29,
      32, 35, 36, 37, 38, 39, 48, 49, 50, 51, 52: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // Constant-valued offsets: {hit, value}
  function automatic logic [REG_W:0] fixed_word(widx_t ix);
    int n;
    n = int'(ix);
    case (n)
      17:      return {1'b1, word_t'(32'h0000_0001)};
      20:      return {1'b1, word_t'(32'h0000_1000)};
      33:      return {1'b1, word_t'(32'h0200_0000)};
      34:      return {1'b1, word_t'(32'hFF00_0000)};
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/sysctl_lock.sv
module sysctl_lock
  import sysctl_pkg::*;
#(
  parameter key_t KEY = 16'hA05F
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  soft_clr,
  input  logic  wr_en,
  input  word_t wdata,
  output key_t  key_q,
  output logic  open
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        key_q <= '0;
    else if (soft_clr) key_q <= '0;
    else if (wr_en)    key_q <= lock_next(wdata, KEY);
  end

  assign open = (key_q == KEY);

  // R3: a set top bit only ever comes from the exact key
  p_top_bit_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
    key_q[LOCK_W-1] |-> (key_q == KEY));

  // R3: any non-key write leaves the lock in the locked state
  p_nonkey_locks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !soft_clr && (wdata != word_t'(KEY))) |=> !key_q[LOCK_W-1]);
endmodule

// File: rtl/sysctl_flagword.sv
module sysctl_flagword
  import sysctl_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  soft_clr,
  input  logic  set_en,
  input  logic  clr_en,
  input  word_t wdata,
  output word_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q <= '0;
    else if (soft_clr) q <= '0;
    else               q <= flag_next(q, set_en, clr_en, wdata);
  end

  // R6/R7: every written one is present after a set
  p_set_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && !soft_clr) |=> ((q & $past(wdata)) == $past(wdata)));

  // R6/R7: every written one is gone after a clear
  p_clr_ones_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !soft_clr) |=> ((q & $past(wdata)) == '0));

  // R8: without a strobe or soft clear the word holds
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_en && !clr_en && !soft_clr) |=> $stable(q));
endmodule

// File: rtl/sysctl_rdport.sv
module sysctl_rdport
  import sysctl_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  rd_en,
  input  logic  aligned,
  input  widx_t idx,
  input  word_t board_id,
  input  word_t lamp,
  input  key_t  key,
  input  word_t cfg_a,
  input  word_t cfg_b,
  input  word_t vflags,
  input  word_t nvflags,
  input  word_t rstctl,
  output word_t rdata,
  output logic  rd_err
);
  logic [REG_W:0] fixed;
  logic           hit;
  word_t          val;

  always_comb begin
    fixed = fixed_word(idx);
    hit   = 1'b1;
    val   = '0;
    if (!aligned) begin
      hit = 1'b0;
    end else begin
      case (idx)
        WX_BOARD:  val = board_id;
        WX_LAMP:   val = lamp;
        WX_KEY:    val = word_t'(key);
        WX_CFG_A:  val = cfg_a;
        WX_CFG_B:  val = cfg_b;
        WX_VF_SET: val = vflags;
        WX_NV_SET: val = nvflags;
        WX_RSTCTL: val = rstctl;
        default: begin
          if (fixed[REG_W])      val = fixed[REG_W-1:0];
          else if (!is_quiet(idx)) hit = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rd_err <= 1'b0;
    end else begin
      rd_err <= rd_en && !hit;
      if (rd_en) rdata <= hit ? val : '0;
    end
  end

  // R10: an error read returns zero data
  p_err_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |-> (rdata == '0));

  // R10: the error flag only follows a read strobe
  p_err_after_rd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |-> $past(rd_en));

  // R11: read data holds while no read is issued
  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
  import sysctl_pkg::*;
#(
  parameter word_t BOARD_ID   = 32'h1780_0500,
  parameter key_t  UNLOCK_KEY = 16'hA05F,
  parameter int    RST_BIT    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [REG_W-1:0]  bus_wdata,
  input  logic              bus_rd,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              rd_err,
  output logic              board_rst_req
);
  localparam int NUM_FLAGS = 2;  // 0: volatile, 1: persistent

  widx_t word_idx;
  logic  aligned;
  logic  wr_hit;
  assign word_idx = bus_addr[ADDR_W-1:2];
  assign aligned  = (bus_addr[1:0] == 2'b00);
  assign wr_hit   = bus_wr && aligned;

  // Named write events
  logic wr_lamp, wr_key, wr_cfg_a, wr_cfg_b, wr_rstctl;
  assign wr_lamp   = wr_hit && (word_idx == WX_LAMP);
  assign wr_key    = wr_hit && (word_idx == WX_KEY);
  assign wr_cfg_a  = wr_hit && (word_idx == WX_CFG_A);
  assign wr_cfg_b  = wr_hit && (word_idx == WX_CFG_B);
  assign wr_rstctl = wr_hit && (word_idx == WX_RSTCTL);

  logic soft_clr;
  logic lock_open;
  logic rst_wr_ok;
  key_t key_q;
  assign soft_clr  = board_rst_req;
  assign rst_wr_ok = wr_rstctl && lock_open;

  word_t lamp_q, cfg_a_q, cfg_b_q, rstctl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lamp_q   <= '0;
      cfg_a_q  <= '0;
      cfg_b_q  <= '0;
      rstctl_q <= '0;
    end else if (soft_clr) begin
      lamp_q   <= '0;
      cfg_a_q  <= '0;
      cfg_b_q  <= '0;
      rstctl_q <= '0;
    end else begin
      if (wr_lamp)   lamp_q   <= bus_wdata;
      if (wr_cfg_a)  cfg_a_q  <= bus_wdata;
      if (wr_cfg_b)  cfg_b_q  <= bus_wdata;
      if (rst_wr_ok) rstctl_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) board_rst_req <= 1'b0;
    else        board_rst_req <= rst_wr_ok && bus_wdata[RST_BIT] && !soft_clr;
  end

  sysctl_lock #(.KEY(UNLOCK_KEY)) u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_clr (soft_clr),
    .wr_en    (wr_key),
    .wdata    (bus_wdata),
    .key_q    (key_q),
    .open     (lock_open)
  );

  // Flag words: same structure, only the soft-clear reach differs
  word_t flag_q  [NUM_FLAGS];
  logic  flag_set[NUM_FLAGS];
  logic  flag_clr[NUM_FLAGS];

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    localparam widx_t SET_IX = (g == 0) ? WX_VF_SET : WX_NV_SET;
    localparam widx_t CLR_IX = (g == 0) ? WX_VF_CLR : WX_NV_CLR;
    localparam logic  SOFT   = (g == 0);
    assign flag_set[g] = wr_hit && (word_idx == SET_IX);
    assign flag_clr[g] = wr_hit && (word_idx == CLR_IX);
    sysctl_flagword u_word (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_clr (soft_clr && SOFT),
      .set_en   (flag_set[g]),
      .clr_en   (flag_clr[g]),
      .wdata    (bus_wdata),
      .q        (flag_q[g])
    );
  end

  sysctl_rdport u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (bus_rd),
    .aligned  (aligned),
    .idx      (word_idx),
    .board_id (BOARD_ID),
    .lamp     (lamp_q),
    .key      (key_q),
    .cfg_a    (cfg_a_q),
    .cfg_b    (cfg_b_q),
    .vflags   (flag_q[0]),
    .nvflags  (flag_q[1]),
    .rstctl   (rstctl_q),
    .rdata    (bus_rdata),
    .rd_err   (rd_err)
  );

  // R4: reset control cannot move while the lock is closed
  p_rstctl_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_open && !soft_clr) |=> $stable(rstctl_q));

  // R5: the request never lasts two cycles
  p_req_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    board_rst_req |=> !board_rst_req);

  // R5: the request only follows a reset-control write with the lock open
  p_req_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    board_rst_req |-> $past(wr_rstctl && lock_open));

  // R8: the soft clear leaves the persistent flags alone
  p_nv_survive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_clr && !flag_set[1] && !flag_clr[1]) |=> $stable(flag_q[1]));

  // R8: volatile words are zero after the soft clear
  p_soft_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (lamp_q == '0 && key_q == '0 && flag_q[0] == '0));
endmodule

// File: tb/sysctl_regbank_test.sv
module sysctl_regbank_test;
  localparam int          CLK_PERIOD = 10;
  localparam int          WDOG_CYC   = 150000;
  localparam logic [31:0] ID_VAL     = 32'h1780_0500;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic        bus_rd;
  logic [31:0] bus_rdata;
  logic        rd_err;
  logic        board_rst_req;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  sysctl_regbank #(.BOARD_ID(ID_VAL)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .rd_err(rd_err), .board_rst_req(board_rst_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Bench model of the register state
  logic [31:0] m_led, m_cfga, m_cfgb, m_fl, m_nv, m_rc;
  logic [15:0] m_lock;

  task automatic model_por();
    m_led = 0; m_cfga = 0; m_cfgb = 0; m_fl = 0; m_nv = 0; m_rc = 0; m_lock = 0;
  endtask

  task automatic model_soft();
    m_led = 0; m_cfga = 0; m_cfgb = 0; m_fl = 0; m_rc = 0; m_lock = 0;
  endtask

  task automatic model_write(input logic [11:0] a, input logic [31:0] d, output logic req);
    req = 1'b0;
    case (a)
      12'h008: m_led  = d;
      12'h020: m_lock = (d == 32'h0000_A05F) ? 16'hA05F : {1'b0, d[14:0]};
      12'h028: m_cfga = d;
      12'h02C: m_cfgb = d;
      12'h030: m_fl   = m_fl | d;
      12'h034: m_fl   = m_fl & ~d;
      12'h038: m_nv   = m_nv | d;
      12'h03C: m_nv   = m_nv & ~d;
      12'h040: if (m_lock == 16'hA05F) begin m_rc = d; req = d[8]; end
      default: ;
    endcase
  endtask

  // {err, data}
  function automatic logic [32:0] exp_rd(input logic [11:0] a);
    case (a)
      12'h000: return {1'b0, ID_VAL};
      12'h008: return {1'b0, m_led};
      12'h020: return {1'b0, 16'h0, m_lock};
      12'h028: return {1'b0, m_cfga};
      12'h02C: return {1'b0, m_cfgb};
      12'h030: return {1'b0, m_fl};
      12'h038: return {1'b0, m_nv};
      12'h040: return {1'b0, m_rc};
      12'h044: return {1'b0, 32'h0000_0001};
      12'h050: return {1'b0, 32'h0000_1000};
      12'h084: return {1'b0, 32'h0200_0000};
      12'h088: return {1'b0, 32'hFF00_0000};
      12'h004, 12'h00C, 12'h010, 12'h014, 12'h018, 12'h01C, 12'h024,
      12'h048, 12'h04C, 12'h054, 12'h058, 12'h05C, 12'h060, 12'h064,
      12'h068, 12'h06C, 12'h070, 12'h074, 12'h080, 12'h08C, 12'h090,
      12'h094, 12'h098, 12'h09C, 12'h0C0, 12'h0C4, 12'h0C8, 12'h0CC,
      12'h0D0: return {1'b0, 32'h0};
      default: return {1'b1, 32'h0};
    endcase
  endfunction

  function automatic string tag_for(input logic [11:0] a);
    case (a)
      12'h000: return "R1";
      12'h008, 12'h028, 12'h02C: return "R2";
      12'h020: return "R3";
      12'h040: return "R4";
      12'h030: return "R6";
      12'h038: return "R7";
      default: return exp_rd(a)[32] ? "R10" : "R9";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [11:0] a, input logic [31:0] d);
    logic exp_req;
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    model_write(a, d, exp_req);
    chk("R5 request after write", {31'h0, board_rst_req}, {31'h0, exp_req});
    if (exp_req) begin
      @(negedge clk);
      chk("R5 request one cycle", {31'h0, board_rst_req}, 32'h0);
      model_soft();
    end
  endtask

  task automatic chk_read(input logic [11:0] a, input string tag);
    logic [32:0] e;
    e = exp_rd(a);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    chk(tag, bus_rdata, e[31:0]);
    chk(tag, {31'h0, rd_err}, {31'h0, e[32]});
  endtask

  task automatic sweep_read();
    for (int i = 0; i < 1024; i++) chk_read(12'(i * 4), tag_for(12'(i * 4)));
  endtask

  task automatic sweep_write(input logic [31:0] d);
    for (int i = 0; i < 1024; i++) do_write(12'(i * 4), d);
  endtask

  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got %08h expected %08h", 32'h0, 32'h1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [32:0] e;
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0; bus_rd = 1'b0;
    model_por();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 rdata at reset", bus_rdata, 32'h0);
    chk("R1 rd_err at reset", {31'h0, rd_err}, 32'h0);
    chk("R1 request at reset", {31'h0, board_rst_req}, 32'h0);

    // Whole window after reset
    sweep_read();

    // R2 plain registers
    do_write(12'h008, 32'hDEAD_BEEF); chk_read(12'h008, "R2 LED");
    do_write(12'h028, 32'h1234_5678); chk_read(12'h028, "R2 cfg A");
    do_write(12'h02C, 32'h8765_4321); chk_read(12'h02C, "R2 cfg B");

    // R3 lock stores
    do_write(12'h020, 32'h1234_FFFF); chk_read(12'h020, "R3 forced bit 15");
    do_write(12'h020, 32'h0001_A05F); chk_read(12'h020, "R3 near-miss key");
    // R4 locked write ignored
    do_write(12'h040, 32'h0000_0155); chk_read(12'h040, "R4 locked write");
    do_write(12'h020, 32'h0000_A05F); chk_read(12'h020, "R3 exact key");
    do_write(12'h040, 32'h0000_0055); chk_read(12'h040, "R4 unlocked write");

    // R6/R7 partial set and clear
    do_write(12'h030, 32'h0000_00F0); do_write(12'h030, 32'h0F00_000F);
    chk_read(12'h030, "R6 set OR");
    do_write(12'h034, 32'h0F00_0030); chk_read(12'h030, "R6 clear");
    chk_read(12'h034, "R10 clear alias read");
    do_write(12'h038, 32'hF0F0_0F0F); do_write(12'h038, 32'h0000_8000);
    chk_read(12'h038, "R7 set OR");
    do_write(12'h03C, 32'h00F0_0003); chk_read(12'h038, "R7 clear");
    chk_read(12'h03C, "R10 clear alias read");

    // R5/R8 board reset request and soft clear
    do_write(12'h040, 32'h0000_0100);
    chk_read(12'h008, "R8 LED cleared");
    chk_read(12'h020, "R8 lock cleared");
    chk_read(12'h028, "R8 cfg cleared");
    chk_read(12'h030, "R8 flags cleared");
    chk_read(12'h040, "R8 reset control cleared");
    chk_read(12'h038, "R8 persistent flags kept");
    do_write(12'h040, 32'h0000_0100); // locked again: no request
    chk_read(12'h038, "R8 persistent flags still kept");

    // R9 writes to constant offsets have no effect
    do_write(12'h044, 32'hFFFF_FFFF); chk_read(12'h044, "R9 const 0x44");
    do_write(12'h050, 32'h0); chk_read(12'h050, "R9 const 0x50");
    do_write(12'h004, 32'hFFFF_FFFF); chk_read(12'h004, "R9 zero 0x04");

    // R10 misaligned accesses
    chk_read(12'h002, "R10 misaligned read");
    chk_read(12'h009, "R10 misaligned read");
    do_write(12'h008, 32'h0000_00AA);
    do_write(12'h00A, 32'hFFFF_0000); chk_read(12'h008, "R10 misaligned write");
    do_write(12'h0E0, 32'hFFFF_FFFF); chk_read(12'h0E0, "R10 undecoded");

    // R11 hold and read/write collision
    chk_read(12'h000, "R11 read ID");
    @(negedge clk);
    chk("R11 hold", bus_rdata, ID_VAL);
    e = exp_rd(12'h008);
    @(negedge clk);
    bus_addr = 12'h008; bus_rd = 1'b1; bus_wr = 1'b1; bus_wdata = 32'h5555_0001;
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
    chk("R11 old value on collision", bus_rdata, e[31:0]);
    begin
      logic r;
      model_write(12'h008, 32'h5555_0001, r);
    end
    chk_read(12'h008, "R11 new value after collision");

    // Whole-window write passes
    sweep_write(32'hFFFF_FFFF); sweep_read();
    sweep_write(32'h0000_A05F); sweep_read();
    sweep_write(32'h0000_0100); sweep_read();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule